// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a virtual address into a physical one through a small table of segment descriptors. The upper bits of the virtual address pick a descriptor. The lower bits are an offset into that segment. Each descriptor holds a physical base, a length limit, a write-permission flag and a present flag. The physical address is the base plus the offset. The block checks the offset against the limit and checks a write against the permission flag. If either check fails, or the descriptor is absent, the block reports a fault code and gives no address.

The descriptor table is loaded through a configuration port. Only requests that carry the kernel qualifier can change the table. A user-mode update attempt leaves the table as it was and raises a denial pulse.

On a process switch, privileged code clears every descriptor with a single flush. It then writes the new process's descriptors one per cycle, so the table always describes the running process. Table updates take effect in the same cycle they are issued, so a translation issued alongside an update already sees the new contents.

Top module: `seg_xlate_unit`

## Requirements
- R1: The segment number is virtual address bits [22:20] and the offset is bits [19:0], so 0x102000 selects segment 1 at offset 0x02000.
- R2: A request with no fault returns `resp_valid` high exactly one cycle later, with `resp_pa` equal to descriptor base plus offset modulo 2^32 and `resp_fault` = 0.
- R3: When the offset is greater than or equal to the descriptor's 21-bit limit, the response carries fault code 1 (bound) and `resp_pa` = 0. A limit of 0 rejects every offset, and a limit of 0x100000 accepts every offset.
- R4: A write request to a descriptor whose writable flag is 0 returns fault code 2 (protection) with `resp_pa` = 0. A read request never returns code 2.
- R5: A request to a descriptor whose present flag is 0 returns fault code 3 (not present). When several faults apply, not present wins over bound, and bound wins over protection.
- R6: A table write or flush with `cfg_kernel` = 1 takes effect. With `cfg_kernel` = 0 it leaves the table unchanged, and `cfg_denied` pulses high one cycle later. Otherwise `cfg_denied` stays low.
- R7: A kernel flush clears the present flag of every descriptor. If a kernel write arrives in the same cycle, the written descriptor keeps the written contents, including its present flag.
- R8: A translation issued in the same cycle as a table write or flush uses the updated table contents.
- R9: After reset every descriptor is not present and all outputs are 0.
- R10: A cycle with no request gives `resp_valid`, `resp_pa` and `resp_fault` all 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 23 | Virtual address: segment in [22:20], offset in [19:0] |
| req_write | input | 1 | 1 = write access, 0 = read access |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_flush | input | 1 | Clear the present flag of all descriptors |
| cfg_kernel | input | 1 | Privilege qualifier for `cfg_we` and `cfg_flush` |
| cfg_idx | input | 3 | Descriptor index to write |
| cfg_base | input | 32 | Physical base for the written descriptor |
| cfg_limit | input | 21 | Segment length for the written descriptor |
| cfg_writable | input | 1 | Writable flag for the written descriptor |
| cfg_present | input | 1 | Present flag for the written descriptor |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_pa | output | 32 | Physical address, 0 on a fault |
| resp_fault | output | 2 | 0 none, 1 bound, 2 protection, 3 not present |
| cfg_denied | output | 1 | Pulse: a user-mode table update was refused |

## Verification
The bench probes offsets at limit-1 and at limit, including the two extreme limits. A design with an off-by-one compare would accept the first illegal offset or reject the last legal one.

It issues translations in the same cycle as writes and flushes. A design that reads the stored table instead of the updated one would return the old base or a stale present flag.

It sends requests that break several rules at once, to catch a wrong fault priority. It sends user-mode updates followed by reads, so a leaky privilege gate shows up as a changed address. It also uses a base near the top of the address space to check that the sum wraps.

// File: rtl/seg_xlate_pkg.sv
// Package: shared fault encoding for the segmented translation unit.
// Assumes: the encoding below is visible at the top-level port resp_fault.
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_BOUND  = 2'b01,
        FLT_PROT   = 2'b10,
        FLT_ABSENT = 2'b11
    } seg_fault_e;

endpackage

// File: rtl/seg_desc_table.sv
// Module: seg_desc_table
// Holds SEG_COUNT segment descriptors: base, limit, writable flag, present flag.
// It computes each entry's next state from the already-gated write and flush
// strobes. The lookup port reads that next state, so a lookup in the same cycle
// as an update sees the new contents.
// Assumes: wr_en and flush_en are already qualified by privilege.
// If both are set, the write to wr_idx overrides the flush for that entry.
module seg_desc_table #(
    parameter int SEG_COUNT = 8,
    parameter int SEG_W     = 3,
    parameter int PA_W      = 32,
    parameter int LIM_W     = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             flush_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [LIM_W-1:0] wr_limit,
    input  logic             wr_writable,
    input  logic             wr_present,
    input  logic [SEG_W-1:0] rd_idx,
    output logic [PA_W-1:0]  rd_base,
    output logic [LIM_W-1:0] rd_limit,
    output logic             rd_writable,
    output logic             rd_present
);

    logic [PA_W-1:0]  nxt_base     [SEG_COUNT];
    logic [LIM_W-1:0] nxt_limit    [SEG_COUNT];
    logic             nxt_writable [SEG_COUNT];
    logic             nxt_present  [SEG_COUNT];

    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_entry
        logic [PA_W-1:0]  base_r;
        logic [LIM_W-1:0] limit_r;
        logic             writable_r;
        logic             present_r;
        logic             hit;

        assign hit = wr_en && (wr_idx == SEG_W'(g));

        // Next-state of this entry: write overrides flush, flush clears presence.
        assign nxt_base[g]     = hit ? wr_base     : base_r;
        assign nxt_limit[g]    = hit ? wr_limit    : limit_r;
        assign nxt_writable[g] = hit ? wr_writable : writable_r;
        assign nxt_present[g]  = hit ? wr_present  : (flush_en ? 1'b0 : present_r);

        // Store the entry; reset marks it absent with cleared fields.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_r     <= '0;
                limit_r    <= '0;
                writable_r <= 1'b0;
                present_r  <= 1'b0;
            end else begin
                base_r     <= nxt_base[g];
                limit_r    <= nxt_limit[g];
                writable_r <= nxt_writable[g];
                present_r  <= nxt_present[g];
            end
        end
    end

    // Write-first lookup of the selected entry.
    always_comb begin
        rd_base     = nxt_base[rd_idx];
        rd_limit    = nxt_limit[rd_idx];
        rd_writable = nxt_writable[rd_idx];
        rd_present  = nxt_present[rd_idx];
    end

endmodule

// File: rtl/seg_fault_check.sv
// Module: seg_fault_check
// Combinational check of one access against one descriptor.
// Fault priority: absent, then bound, then protection.
// It produces base + offset only when there is no fault, and zero otherwise.
// Assumes: LIM_W = OFS_W + 1, so a limit can cover the full offset range.
module seg_fault_check
    import seg_xlate_pkg::*;
#(
    parameter int OFS_W = 20,
    parameter int PA_W  = 32,
    parameter int LIM_W = 21
) (
    input  logic [OFS_W-1:0] offset,
    input  logic             is_write,
    input  logic [PA_W-1:0]  base,
    input  logic [LIM_W-1:0] limit,
    input  logic             writable,
    input  logic             present,
    output seg_fault_e       fault,
    output logic [PA_W-1:0]  pa
);

    logic [LIM_W-1:0] ofs_ext;
    assign ofs_ext = LIM_W'(offset);

    // Pick the highest-priority violation.
    always_comb begin
        if (!present)              fault = FLT_ABSENT;
        else if (ofs_ext >= limit) fault = FLT_BOUND;
        else if (is_write && !writable) fault = FLT_PROT;
        else                       fault = FLT_NONE;
    end

    // Relocate the offset; withhold the address on any fault.
    always_comb begin
        pa = (fault == FLT_NONE) ? (base + PA_W'(offset)) : '0;
    end

endmodule

// File: rtl/seg_xlate_unit.sv
// Module: seg_xlate_unit (top)
// Translates {segment, offset} virtual addresses through a descriptor table.
// It registers the result one cycle later. It gates table updates with the
// kernel qualifier and pulses cfg_denied for each user-mode attempt.
// Assumes: synchronous active-low reset; at most one request per cycle.
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int SEG_COUNT = 8,
    parameter int OFS_W     = 20,
    parameter int PA_W      = 32,
    localparam int SEG_W    = $clog2(SEG_COUNT),
    localparam int VA_W     = SEG_W + OFS_W,
    localparam int LIM_W    = OFS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_write,
    input  logic             cfg_we,
    input  logic             cfg_flush,
    input  logic             cfg_kernel,
    input  logic [SEG_W-1:0] cfg_idx,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [LIM_W-1:0] cfg_limit,
    input  logic             cfg_writable,
    input  logic             cfg_present,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_pa,
    output logic [1:0]       resp_fault,
    output logic             cfg_denied
);

    logic             wr_go;
    logic             flush_go;
    logic             deny_d;
    logic [SEG_W-1:0] seg_sel;
    logic [OFS_W-1:0] seg_ofs;
    logic [PA_W-1:0]  d_base;
    logic [LIM_W-1:0] d_limit;
    logic             d_writable;
    logic             d_present;
    seg_fault_e       chk_fault;
    logic [PA_W-1:0]  chk_pa;

    // Privilege gate on the configuration port.
    always_comb begin
        wr_go    = cfg_we && cfg_kernel;
        flush_go = cfg_flush && cfg_kernel;
        deny_d   = (cfg_we || cfg_flush) && !cfg_kernel;
    end

    // Split the virtual address into segment number and offset.
    assign seg_sel = req_va[VA_W-1:OFS_W];
    assign seg_ofs = req_va[OFS_W-1:0];

    seg_desc_table #(
        .SEG_COUNT (SEG_COUNT),
        .SEG_W     (SEG_W),
        .PA_W      (PA_W),
        .LIM_W     (LIM_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_go),
        .flush_en    (flush_go),
        .wr_idx      (cfg_idx),
        .wr_base     (cfg_base),
        .wr_limit    (cfg_limit),
        .wr_writable (cfg_writable),
        .wr_present  (cfg_present),
        .rd_idx      (seg_sel),
        .rd_base     (d_base),
        .rd_limit    (d_limit),
        .rd_writable (d_writable),
        .rd_present  (d_present)
    );

    seg_fault_check #(
        .OFS_W (OFS_W),
        .PA_W  (PA_W),
        .LIM_W (LIM_W)
    ) u_check (
        .offset   (seg_ofs),
        .is_write (req_write),
        .base     (d_base),
        .limit    (d_limit),
        .writable (d_writable),
        .present  (d_present),
        .fault    (chk_fault),
        .pa       (chk_pa)
    );

    // Response register: result one cycle after the request, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_pa    <= '0;
            resp_fault <= 2'b00;
            cfg_denied <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_pa    <= req_valid ? chk_pa : '0;
            resp_fault <= req_valid ? chk_fault : FLT_NONE;
            cfg_denied <= deny_d;
        end
    end

endmodule

// File: rtl/seg_xlate_unit_chk.sv
// Module: seg_xlate_unit_chk
// Port-level temporal properties of seg_xlate_unit, attached with bind below.
// Assumes: synchronous active-low reset held for at least one clock edge.
module seg_xlate_unit_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_write,
    input logic            cfg_we,
    input logic            cfg_flush,
    input logic            cfg_kernel,
    input logic            resp_valid,
    input logic [PA_W-1:0] resp_pa,
    input logic [1:0]      resp_fault,
    input logic            cfg_denied
);

    a_r2_resp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && resp_fault == 2'b00 && resp_pa == '0));

    a_r3_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_fault != 2'b00) |-> (resp_pa == '0));

    a_r4_read_no_prot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (resp_fault != 2'b10));

    a_r6_user_denied: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_we || cfg_flush) && !cfg_kernel) |=> cfg_denied);

    a_r6_no_spurious_deny: assert property (@(posedge clk) disable iff (!rst_n)
        !((cfg_we || cfg_flush) && !cfg_kernel) |=> !cfg_denied);

    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!resp_valid && !cfg_denied && resp_fault == 2'b00));

endmodule

bind seg_xlate_unit seg_xlate_unit_chk #(.PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .cfg_we     (cfg_we),
    .cfg_flush  (cfg_flush),
    .cfg_kernel (cfg_kernel),
    .resp_valid (resp_valid),
    .resp_pa    (resp_pa),
    .resp_fault (resp_fault),
    .cfg_denied (cfg_denied)
);

// File: tb/seg_xlate_unit_bench.sv
// Bench for seg_xlate_unit: directed corner cases, then seeded random traffic
// checked against a bench-side descriptor model.
module seg_xlate_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [22:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_flush = 1'b0;
    logic        cfg_kernel = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [20:0] cfg_limit = '0;
    logic        cfg_writable = 1'b0;
    logic        cfg_present = 1'b0;
    logic        resp_valid;
    logic [31:0] resp_pa;
    logic [1:0]  resp_fault;
    logic        cfg_denied;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_base  [8];
    logic [20:0] m_limit [8];
    logic        m_wr    [8];
    logic        m_pres  [8];

    always #2 clk = ~clk;

    seg_xlate_unit u_seg_xlate_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .cfg_we(cfg_we), .cfg_flush(cfg_flush),
        .cfg_kernel(cfg_kernel), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_writable(cfg_writable),
        .cfg_present(cfg_present), .resp_valid(resp_valid), .resp_pa(resp_pa),
        .resp_fault(resp_fault), .cfg_denied(cfg_denied)
    );

    function automatic logic [1:0] exp_fault(input logic [2:0] s,
                                             input logic [19:0] o,
                                             input logic w);
        if (!m_pres[s])                exp_fault = 2'd3;
        else if ({1'b0, o} >= m_limit[s]) exp_fault = 2'd1;
        else if (w && !m_wr[s])        exp_fault = 2'd2;
        else                           exp_fault = 2'd0;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got 0x%0h exp 0x%0h", tag, what, got, exp);
        end
    endtask

    // One cycle: drive, update model write-first, then check the registered result.
    task automatic cyc(input logic rv, input logic [22:0] va, input logic w,
                       input logic we, input logic fl, input logic kern,
                       input logic [2:0] idx, input logic [31:0] b,
                       input logic [20:0] lim, input logic wrt, input logic pres,
                       input string tag);
        logic [1:0]  ef;
        logic [31:0] epa;
        logic        edeny;
        req_valid = rv; req_va = va; req_write = w;
        cfg_we = we; cfg_flush = fl; cfg_kernel = kern; cfg_idx = idx;
        cfg_base = b; cfg_limit = lim; cfg_writable = wrt; cfg_present = pres;
        edeny = (we || fl) && !kern;
        if (kern && fl) for (int i = 0; i < 8; i++) m_pres[i] = 1'b0;
        if (kern && we) begin
            m_base[idx] = b; m_limit[idx] = lim; m_wr[idx] = wrt; m_pres[idx] = pres;
        end
        ef  = rv ? exp_fault(va[22:20], va[19:0], w) : 2'd0;
        epa = (rv && ef == 2'd0) ? m_base[va[22:20]] + {12'd0, va[19:0]} : 32'd0;
        @(posedge clk);
        #1;
        check(rv ? tag : "R10", "resp_valid", {31'd0, resp_valid}, {31'd0, rv});
        check(tag, "resp_fault", {30'd0, resp_fault}, {30'd0, ef});
        check(tag, "resp_pa", resp_pa, epa);
        check("R6", "cfg_denied", {31'd0, cfg_denied}, {31'd0, edeny});
    endtask

    task automatic rd(input logic [22:0] va, input logic w, input string tag);
        cyc(1'b1, va, w, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0, 21'd0, 1'b0, 1'b0, tag);
    endtask

    task automatic kwr(input logic [2:0] idx, input logic [31:0] b,
                       input logic [20:0] lim, input logic wrt, input string tag);
        cyc(1'b0, 23'd0, 1'b0, 1'b1, 1'b0, 1'b1, idx, b, lim, wrt, 1'b1, tag);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0; m_limit[i] = '0; m_wr[i] = 1'b0; m_pres[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state at the outputs
        check("R9", "resp_valid", {31'd0, resp_valid}, 32'd0);
        check("R9", "resp_fault", {30'd0, resp_fault}, 32'd0);
        check("R9", "cfg_denied", {31'd0, cfg_denied}, 32'd0);
        rst_n = 1'b1;
        // R9/R5: every descriptor absent after reset
        rd({3'd0, 20'h00000}, 1'b0, "R9");
        rd({3'd7, 20'h00010}, 1'b1, "R5");
        // R8/R1/R2: write segment 1 and translate in the same cycle
        cyc(1'b1, 23'h102000, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 32'h14000,
            21'h05000, 1'b1, 1'b1, "R8");
        rd(23'h104FFF, 1'b1, "R1");
        rd(23'h105000, 1'b0, "R3");
        // R4: read-only segment
        kwr(3'd2, 32'h08000, 21'h00400, 1'b0, "R4");
        rd(23'h200010, 1'b1, "R4");
        rd(23'h200010, 1'b0, "R4");
        // R5: bound wins over protection
        rd(23'h200400, 1'b1, "R5");
        // R3: zero limit and full limit
        kwr(3'd3, 32'h40000, 21'h000000, 1'b1, "R3");
        rd(23'h300000, 1'b0, "R3");
        kwr(3'd4, 32'h80000000, 21'h100000, 1'b1, "R3");
        rd(23'h4FFFFF, 1'b1, "R3");
        // R2: address wraps modulo 2^32
        kwr(3'd5, 32'hFFFFF000, 21'h010000, 1'b1, "R2");
        rd(23'h502000, 1'b0, "R2");
        // R6: user write is refused and leaves segment 1 intact
        cyc(1'b0, 23'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 32'h99000, 21'h00010,
            1'b0, 1'b0, "R6");
        rd(23'h102000, 1'b1, "R6");
        // R6: user flush is refused
        cyc(1'b0, 23'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 32'd0, 21'd0, 1'b0,
            1'b0, "R6");
        rd(23'h100004, 1'b0, "R6");
        // R10: idle cycle
        cyc(1'b0, 23'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0, 21'd0, 1'b0,
            1'b0, "R10");
        // R7/R8: kernel flush with a same-cycle translation
        cyc(1'b1, 23'h102000, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 32'd0, 21'd0,
            1'b0, 1'b0, "R8");
        // R7: flush plus write together keeps the written entry
        cyc(1'b0, 23'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd2, 32'h7A000, 21'h03200,
            1'b1, 1'b1, "R7");
        rd(23'h203000, 1'b1, "R7");
        rd(23'h400000, 1'b0, "R7");
        // Seeded random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [2:0]  s;
            logic [19:0] o;
            logic [20:0] lim;
            logic [1:0]  ef;
            int r;
            string tag;
            r = $urandom_range(0, 99);
            s = 3'($urandom_range(0, 7));
            case ($urandom_range(0, 2))
                0: o = 20'(m_limit[s] - 21'd1);
                1: o = m_limit[s][19:0];
                default: o = 20'($urandom);
            endcase
            case ($urandom_range(0, 3))
                0: lim = 21'd0;
                1: lim = 21'h100000;
                2: lim = 21'($urandom_range(1, 64));
                default: lim = 21'($urandom_range(0, 21'h100000));
            endcase
            ef = exp_fault(s, o, 1'b0);
            case (ef)
                2'd0: tag = "R2";
                2'd1: tag = "R3";
                default: tag = "R5";
            endcase
            if (r < 30) tag = "R8";
            cyc(($urandom_range(0, 3) != 0), {s, o}, 1'($urandom),
                (r < 30), (r >= 97), ($urandom_range(0, 9) != 0),
                3'($urandom_range(0, 7)), $urandom, lim, 1'($urandom),
                ($urandom_range(0, 7) != 0), tag);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule